// File: doc/BRIEF.md
# TLB Entry Permission Checker

This block takes one TLB entry that a lookup has already matched and decides whether an access may use it. The entry covers two neighbouring pages, an even one and an odd one, each with its own valid, dirty, privilege, restricted-privilege, no-execute, no-read and physical page number fields. The checker picks the half from the virtual address, runs the access-rights tests in a fixed order, and returns a 3-bit result code. It also returns the physical address and the read, write and execute grants.

The page size comes from the entry itself when the entry lives in the fully associative region of the TLB. Otherwise it comes from a single page-size value shared by the set-associative region. The decision is combinational. The result is captured in a register stage, so it appears one clock after the request.

Top module: `tlb_perm_check`

## Requirements
- R1: While reset is held and until the first request, rsp_vld, rsp_code, rsp_pa, rsp_rd, rsp_wr and rsp_ex are all 0.
- R2: A request presented with req_vld high produces its result and rsp_vld high on the next clock. When req_vld is low, rsp_vld drops to 0 and the other outputs keep their previous values.
- R3: The effective page size is ent_ps when ent_idx is at least ASSOC_BASE (default 2048), and glob_ps when it is below.
- R4: The odd half (bit 1 of each per-half field, upper slice of pg_plv and pg_ppn) is used when vaddr[page size] is 1. The even half (bit 0, lower slice) is used when that bit is 0.
- R5: Result codes are 0 match, 3 invalid, 4 dirty fault, 5 read inhibit, 6 execute inhibit and 7 privilege error. Codes 1 and 2 are reserved for the surrounding lookup and are never produced.
- R6: Access type is 0 fetch, 1 load, 2 store (3 gets only the valid and privilege tests). The first failing test wins, in this order: valid clear gives 3; a fetch with no-execute set gives 6; a load with no-read set gives 5; the privilege test gives 7; a store with dirty clear gives 4.
- R7: With the selected restricted-privilege bit 0, the privilege test fails when cur_plv is numerically greater than the entry level. With it set to 1, the test fails when the two levels differ.
- R8: On a match, rsp_pa is the selected page number shifted left by 12, ORed with the vaddr bits below the page size.
- R9: On a match, rsp_rd is 1, rsp_wr equals the selected dirty bit, and rsp_ex is the inverse of the selected no-execute bit.
- R10: Whenever rsp_code is not 0, rsp_pa, rsp_rd, rsp_wr and rsp_ex are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Request present this cycle |
| vaddr | input | VA_W | Virtual address |
| acc_type | input | 2 | 0 fetch, 1 load, 2 store |
| cur_plv | input | 2 | Current privilege level, 0 to 3 |
| ent_idx | input | IDX_W | Index of the matched entry |
| ent_ps | input | 6 | Entry page size, 12 to 30 |
| glob_ps | input | 6 | Shared set-associative page size, 12 to 30 |
| pg_valid | input | 2 | Valid bits, bit 1 odd, bit 0 even |
| pg_dirty | input | 2 | Dirty bits per half |
| pg_rplv | input | 2 | Restricted-privilege bits per half |
| pg_nx | input | 2 | No-execute bits per half |
| pg_nr | input | 2 | No-read bits per half |
| pg_plv | input | 4 | Privilege level per half, [3:2] odd, [1:0] even |
| pg_ppn | input | 2*(PA_W-12) | Physical page numbers, upper slice odd |
| rsp_vld | output | 1 | Result valid |
| rsp_code | output | 3 | Result code |
| rsp_pa | output | PA_W | Physical address |
| rsp_rd | output | 1 | Read granted |
| rsp_wr | output | 1 | Write granted |
| rsp_ex | output | 1 | Execute granted |

## Verification
The hardest situation to reach from the ports is an entry whose two halves disagree, combined with a page size whose selection bit differs from the bit a different page size would pick. A wrong page-size source or half select then still produces a plausible code. The bench builds entries with one half faulting and the other clean. It sets vaddr so that bit 12 and the higher page-size bit differ, and swaps ent_idx across ASSOC_BASE, so each mistake turns into a different result code or address.

// File: rtl/tlb_perm_check.sv
module tlb_perm_check #(
  parameter int VA_W       = 48,
  parameter int PA_W       = 48,
  parameter int IDX_W      = 12,
  parameter int ASSOC_BASE = 2048
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_vld,
  input  logic [VA_W-1:0]         vaddr,
  input  logic [1:0]              acc_type,
  input  logic [1:0]              cur_plv,
  input  logic [IDX_W-1:0]        ent_idx,
  input  logic [5:0]              ent_ps,
  input  logic [5:0]              glob_ps,
  input  logic [1:0]              pg_valid,
  input  logic [1:0]              pg_dirty,
  input  logic [1:0]              pg_rplv,
  input  logic [1:0]              pg_nx,
  input  logic [1:0]              pg_nr,
  input  logic [3:0]              pg_plv,
  input  logic [2*(PA_W-12)-1:0]  pg_ppn,
  output logic                    rsp_vld,
  output logic [2:0]              rsp_code,
  output logic [PA_W-1:0]         rsp_pa,
  output logic                    rsp_rd,
  output logic                    rsp_wr,
  output logic                    rsp_ex
);
  localparam int PPN_W = PA_W - 12;

  localparam logic [2:0] C_OK    = 3'd0;
  localparam logic [2:0] C_INVAL = 3'd3;
  localparam logic [2:0] C_DIRTY = 3'd4;
  localparam logic [2:0] C_NORD  = 3'd5;
  localparam logic [2:0] C_NOEX  = 3'd6;
  localparam logic [2:0] C_PRIV  = 3'd7;

  localparam logic [1:0] A_FETCH = 2'd0;
  localparam logic [1:0] A_LOAD  = 2'd1;
  localparam logic [1:0] A_STORE = 2'd2;

  logic [5:0]       ps;
  logic             odd;
  logic             s_v, s_d, s_rplv, s_nx, s_nr;
  logic [1:0]       s_plv;
  logic [PPN_W-1:0] s_ppn;
  logic             priv_bad;
  logic [PA_W-1:0]  off_mask;
  logic [2:0]       code_c;
  logic             ok_c;

  assign ps  = (ent_idx >= IDX_W'(ASSOC_BASE)) ? ent_ps : glob_ps;
  assign odd = vaddr[ps];

  assign s_v    = pg_valid[odd];
  assign s_d    = pg_dirty[odd];
  assign s_rplv = pg_rplv[odd];
  assign s_nx   = pg_nx[odd];
  assign s_nr   = pg_nr[odd];
  assign s_plv  = odd ? pg_plv[3:2] : pg_plv[1:0];
  assign s_ppn  = odd ? pg_ppn[2*PPN_W-1:PPN_W] : pg_ppn[PPN_W-1:0];

  assign priv_bad = s_rplv ? (cur_plv != s_plv) : (cur_plv > s_plv);
  assign off_mask = (PA_W'(1) << ps) - PA_W'(1);

  always_comb begin
    if (!s_v)                               code_c = C_INVAL;
    else if (acc_type == A_FETCH && s_nx)   code_c = C_NOEX;
    else if (acc_type == A_LOAD && s_nr)    code_c = C_NORD;
    else if (priv_bad)                      code_c = C_PRIV;
    else if (acc_type == A_STORE && !s_d)   code_c = C_DIRTY;
    else                                    code_c = C_OK;
  end

  assign ok_c = (code_c == C_OK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_vld  <= 1'b0;
      rsp_code <= C_OK;
      rsp_pa   <= '0;
      rsp_rd   <= 1'b0;
      rsp_wr   <= 1'b0;
      rsp_ex   <= 1'b0;
    end else begin
      rsp_vld <= req_vld;
      if (req_vld) begin
        rsp_code <= code_c;
        rsp_pa   <= ok_c ? ({s_ppn, 12'b0} | (PA_W'(vaddr) & off_mask)) : '0;
        rsp_rd   <= ok_c;
        rsp_wr   <= ok_c & s_d;
        rsp_ex   <= ok_c & ~s_nx;
      end
    end
  end
endmodule

// File: rtl/tlb_perm_check_sva.sv
module tlb_perm_check_sva #(
  parameter int PA_W = 48
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_vld,
  input logic [1:0]      acc_type,
  input logic [1:0]      cur_plv,
  input logic [1:0]      pg_valid,
  input logic [1:0]      pg_dirty,
  input logic [1:0]      pg_rplv,
  input logic [1:0]      pg_nr,
  input logic            rsp_vld,
  input logic [2:0]      rsp_code,
  input logic [PA_W-1:0] rsp_pa,
  input logic            rsp_rd,
  input logic            rsp_wr,
  input logic            rsp_ex
);
  a_r2_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(req_vld)) |-> rsp_vld);

  a_r5_no_reserved_code: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_vld |-> (rsp_code != 3'd1 && rsp_code != 3'd2));

  a_r6_invalid_first: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(req_vld) && $past(pg_valid) == 2'b00) |-> rsp_code == 3'd3);

  a_r6_load_noread: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(req_vld) && $past(acc_type) == 2'd1 &&
     $past(pg_valid) == 2'b11 && $past(pg_nr) == 2'b11) |-> rsp_code == 3'd5);

  a_r6_store_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(req_vld) && $past(acc_type) == 2'd2 && $past(pg_valid) == 2'b11 &&
     $past(pg_dirty) == 2'b00 && $past(cur_plv) == 2'd0 && $past(pg_rplv) == 2'b00)
    |-> rsp_code == 3'd4);

  a_r9_read_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_vld && rsp_code == 3'd0) |-> rsp_rd);

  a_r10_zero_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_code != 3'd0) |-> (rsp_pa == '0 && !rsp_rd && !rsp_wr && !rsp_ex));
endmodule

bind tlb_perm_check tlb_perm_check_sva #(.PA_W(PA_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .acc_type(acc_type), .cur_plv(cur_plv),
  .pg_valid(pg_valid), .pg_dirty(pg_dirty), .pg_rplv(pg_rplv), .pg_nr(pg_nr),
  .rsp_vld(rsp_vld), .rsp_code(rsp_code), .rsp_pa(rsp_pa),
  .rsp_rd(rsp_rd), .rsp_wr(rsp_wr), .rsp_ex(rsp_ex)
);

// File: tb/tlb_perm_check_bench.sv
module tlb_perm_check_bench;
  localparam int CLK_PERIOD = 10;
  localparam int VA_W = 48;
  localparam int PA_W = 48;
  localparam int IDX_W = 12;
  localparam int ASSOC_BASE = 2048;
  localparam int PPN_W = PA_W - 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_vld = 1'b0;
  logic [VA_W-1:0] vaddr = '0;
  logic [1:0] acc_type = '0, cur_plv = '0;
  logic [IDX_W-1:0] ent_idx = '0;
  logic [5:0] ent_ps = 6'd12, glob_ps = 6'd12;
  logic [1:0] pg_valid = '0, pg_dirty = '0, pg_rplv = '0, pg_nx = '0, pg_nr = '0;
  logic [3:0] pg_plv = '0;
  logic [2*PPN_W-1:0] pg_ppn = '0;
  logic rsp_vld, rsp_rd, rsp_wr, rsp_ex;
  logic [2:0] rsp_code;
  logic [PA_W-1:0] rsp_pa;

  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_perm_check #(.VA_W(VA_W), .PA_W(PA_W), .IDX_W(IDX_W), .ASSOC_BASE(ASSOC_BASE)) u_tlb_perm_check (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .vaddr(vaddr), .acc_type(acc_type),
    .cur_plv(cur_plv), .ent_idx(ent_idx), .ent_ps(ent_ps), .glob_ps(glob_ps),
    .pg_valid(pg_valid), .pg_dirty(pg_dirty), .pg_rplv(pg_rplv), .pg_nx(pg_nx),
    .pg_nr(pg_nr), .pg_plv(pg_plv), .pg_ppn(pg_ppn), .rsp_vld(rsp_vld),
    .rsp_code(rsp_code), .rsp_pa(rsp_pa), .rsp_rd(rsp_rd), .rsp_wr(rsp_wr), .rsp_ex(rsp_ex));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] m_code();
    logic [5:0] ps = (ent_idx >= IDX_W'(ASSOC_BASE)) ? ent_ps : glob_ps;
    int h = int'(vaddr[ps]);
    logic [1:0] lv = pg_plv[2*h +: 2];
    logic bad = pg_rplv[h] ? (cur_plv != lv) : (cur_plv > lv);
    if (!pg_valid[h]) return 3'd3;
    if (acc_type == 2'd0 && pg_nx[h]) return 3'd6;
    if (acc_type == 2'd1 && pg_nr[h]) return 3'd5;
    if (bad) return 3'd7;
    if (acc_type == 2'd2 && !pg_dirty[h]) return 3'd4;
    return 3'd0;
  endfunction

  function automatic logic [PA_W-1:0] m_pa();
    logic [5:0] ps = (ent_idx >= IDX_W'(ASSOC_BASE)) ? ent_ps : glob_ps;
    int h = int'(vaddr[ps]);
    logic [PA_W-1:0] base = {pg_ppn[h*PPN_W +: PPN_W], 12'b0};
    logic [PA_W-1:0] off = 0;
    for (int i = 0; i < 31; i++) if (i < int'(ps)) off[i] = vaddr[i];
    return base | off;
  endfunction

  task automatic clean_entry();
    pg_valid = 2'b11; pg_dirty = 2'b11; pg_rplv = 2'b00; pg_nx = 2'b00; pg_nr = 2'b00;
    pg_plv = 4'b1111;
    pg_ppn = {36'h0_000A_BCDE, 36'h0_0001_2345};
    ent_idx = 12'd5; glob_ps = 6'd12; ent_ps = 6'd12; cur_plv = 2'd0; acc_type = 2'd1;
  endtask

  // drive at negedge, capture at posedge, sample at next negedge
  task automatic run(input string req);
    logic [2:0] ec; logic [PA_W-1:0] ep; logic ok;
    ec = m_code(); ok = (ec == 3'd0);
    ep = ok ? m_pa() : '0;
    req_vld = 1'b1;
    @(negedge clk);
    req_vld = 1'b0;
    chk(req, 64'(rsp_vld), 64'd1);
    chk(req, 64'(rsp_code), 64'(ec));
    chk(req, 64'(rsp_pa), 64'(ep));
    chk(req, 64'({rsp_rd, rsp_wr, rsp_ex}), 64'({ok, ok & pg_dirty[int'(rsp_code == 0 ? vaddr[(ent_idx >= IDX_W'(ASSOC_BASE)) ? ent_ps : glob_ps] : 1'b0)], 1'b0}) & 64'(ok ? 3'b110 : 3'b000) | 64'({1'b0, 1'b0, ok & ~pg_nx[int'(vaddr[(ent_idx >= IDX_W'(ASSOC_BASE)) ? ent_ps : glob_ps])]}));
  endtask

  task automatic t_reset();
    chk("R1 vld", 64'(rsp_vld), 64'd0);
    chk("R1 code", 64'(rsp_code), 64'd0);
    chk("R1 pa", 64'(rsp_pa), 64'd0);
    chk("R1 perms", 64'({rsp_rd, rsp_wr, rsp_ex}), 64'd0);
  endtask

  task automatic t_half_select();
    clean_entry();
    vaddr = 48'h0000_1234_5ABC;
    run("R4 odd half");
    chk("R8 odd pa", 64'(rsp_pa), 64'h0000_ABCD_EABC);
    vaddr = 48'h0000_1234_4ABC;
    run("R4 even half");
    chk("R8 even pa", 64'(rsp_pa), 64'h0000_1234_5ABC);
    pg_valid = 2'b01; vaddr = 48'h0000_0000_1000;
    run("R4 odd invalid");
    chk("R4 odd invalid code", 64'(rsp_code), 64'd3);
  endtask

  task automatic t_ps_source();
    clean_entry();
    pg_valid = 2'b01;
    vaddr = 48'h0000_0020_0000; // bit 21 set, bit 12 clear
    ent_ps = 6'd21; glob_ps = 6'd12;
    ent_idx = 12'd2047;
    run("R3 below base uses glob_ps");
    chk("R3 below base code", 64'(rsp_code), 64'd0);
    ent_idx = 12'd2048;
    run("R3 at base uses ent_ps");
    chk("R3 at base code", 64'(rsp_code), 64'd3);
    pg_valid = 2'b11; vaddr = 48'h0000_003F_FFFF; ent_ps = 6'd30;
    run("R8 large page offset");
  endtask

  task automatic t_priority();
    clean_entry(); vaddr = 48'h0;
    pg_valid = 2'b00; pg_nx = 2'b11; pg_nr = 2'b11; acc_type = 2'd0;
    run("R6 invalid beats noexec");
    pg_valid = 2'b11; cur_plv = 2'd3; pg_plv = 4'b0000;
    run("R6 noexec beats priv");
    chk("R5 noexec code", 64'(rsp_code), 64'd6);
    acc_type = 2'd1;
    run("R6 noread beats priv");
    chk("R5 noread code", 64'(rsp_code), 64'd5);
    acc_type = 2'd2; pg_dirty = 2'b00;
    run("R6 priv beats dirty");
    chk("R5 priv code", 64'(rsp_code), 64'd7);
    cur_plv = 2'd0;
    run("R6 store dirty fault");
    chk("R5 dirty code", 64'(rsp_code), 64'd4);
    acc_type = 2'd3;
    run("R6 type 3 skips dirty and nx");
    chk("R9 type 3 perms", 64'({rsp_rd, rsp_wr, rsp_ex}), 64'b100);
  endtask

  task automatic t_privilege();
    clean_entry(); vaddr = 48'h0; pg_plv = 4'b1010;
    cur_plv = 2'd2; run("R7 equal ok");
    chk("R7 equal code", 64'(rsp_code), 64'd0);
    cur_plv = 2'd3; run("R7 greater fails");
    chk("R7 greater code", 64'(rsp_code), 64'd7);
    cur_plv = 2'd1; run("R7 lower ok");
    chk("R7 lower code", 64'(rsp_code), 64'd0);
    pg_rplv = 2'b01; run("R7 restricted lower fails");
    chk("R7 restricted code", 64'(rsp_code), 64'd7);
    cur_plv = 2'd2; run("R7 restricted equal ok");
    chk("R7 restricted equal", 64'(rsp_code), 64'd0);
  endtask

  task automatic t_perms();
    clean_entry(); vaddr = 48'h0000_0000_0123;
    pg_dirty = 2'b10; pg_nx = 2'b01;
    run("R9 even no write no exec");
    chk("R9 even perms", 64'({rsp_rd, rsp_wr, rsp_ex}), 64'b100);
    vaddr = 48'h0000_0000_1123;
    run("R9 odd write exec");
    chk("R9 odd perms", 64'({rsp_rd, rsp_wr, rsp_ex}), 64'b111);
    acc_type = 2'd2; vaddr = 48'h0000_0000_0123;
    run("R10 fault zeroes");
    chk("R10 pa zero", 64'(rsp_pa), 64'd0);
    chk("R10 perms zero", 64'({rsp_rd, rsp_wr, rsp_ex}), 64'd0);
  endtask

  task automatic t_hold();
    logic [2:0] c; logic [PA_W-1:0] p;
    clean_entry(); vaddr = 48'h0000_0000_1777;
    run("R2 capture");
    c = rsp_code; p = rsp_pa;
    pg_valid = 2'b00; vaddr = 48'h0;
    @(negedge clk);
    chk("R2 vld low when idle", 64'(rsp_vld), 64'd0);
    chk("R2 code held", 64'(rsp_code), 64'(c));
    chk("R2 pa held", 64'(rsp_pa), 64'(p));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_half_select();
    t_ps_source();
    t_priority();
    t_privilege();
    t_perms();
    t_hold();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule